// File: doc/BRIEF.md
# Posted-Write Bus Controller

This controller sits between one already-arbitrated internal request port and two targets. Behind that port are a CPU and a DMA engine. The first target is an on-chip memory and register port that completes in a single clock. The second is a slower external memory port. The top address bit chooses the target. When the buffer-enable input is set, an external write is copied into a single-entry buffer and acknowledged at once. The external write sequence then runs from the buffer while later internal accesses go on in parallel, whichever master issues them. DMA dead cycles count as internal accesses.

When the buffer is disabled, or the access is an external read, the requester is held until the external sequence ends. Any new external access waits until the buffer has drained, so a read that follows a buffered write always sees the written data.

The controller also drives an active-low transfer-end strobe for the request flagged as the last one of a DMA transfer. The strobe is always asserted when that request is an external cycle. It is withheld when that request is an internal or dead cycle that overlaps a buffered external write.

Top module: `postwr_bus_ctrl`

## Requirements
- R1: After reset, extCsN, extRdN, extHwrN, extLwrN and tendN are all high, and the buffer is empty.
- R2: When bufEnable is 0, an external write presented while the sequencer is idle gets reqReady only in the WR_CYCLES-th cycle after it was presented (cycle 0 is the cycle of presentation), which is the last cycle of its external sequence.
- R3: When bufEnable is 1, an external write (reqAddr[15]=1) presented while the sequencer is idle gets reqReady in the same cycle. Its external sequence then occupies the next WR_CYCLES cycles.
- R4: Every external sequence is one setup cycle with extCsN low and all strobes high, followed by WR_CYCLES-1 cycles with the strobes active. For a write, extHwrN is low only if reqHiEn was set, which writes bits 15:8, and extLwrN is low only if reqLoEn was set, which writes bits 7:0. extAddr and extWdata hold the buffered values.
- R5: While a buffered write is in progress, an internal read or write (reqAddr[15]=0) gets reqReady in its first cycle, with intSel high.
- R6: An external access presented while the buffer is busy gets no reqReady until the sequence has ended. Its own handling then starts in the first idle cycle.
- R7: An external read gets reqReady in the last cycle of its own sequence, with rspData equal to extRdata. A read that follows a buffered write to the same address returns the written data.
- R8: tendN is low in every cycle of an external sequence whose request had reqLast set, and high again after it.
- R9: For an internal or dead-cycle request with reqLast set, tendN is low in its accept cycle if no external sequence is running. It stays high if a buffered write overlaps that cycle.
- R10: A dead cycle (reqDead=1) is accepted in one cycle like an internal access, overlaps a buffered write, and never raises intSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bufEnable | input | 1 | Allows external writes to be posted to the buffer |
| reqValid | input | 1 | A request is presented |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDead | input | 1 | DMA dead cycle, carries no data |
| reqLast | input | 1 | Request is the final transfer of a DMA transfer |
| reqAddr | input | 16 | Address; bit 15 set selects the external port |
| reqWdata | input | 16 | Write data |
| reqHiEn | input | 1 | Upper byte lane enable |
| reqLoEn | input | 1 | Lower byte lane enable |
| reqReady | output | 1 | Request completes at this clock edge |
| rspData | output | 16 | Read data, valid with reqReady |
| intSel | output | 1 | Internal port access strobe |
| intWrite | output | 1 | Internal port write |
| intAddr | output | 16 | Internal port address |
| intWdata | output | 16 | Internal port write data |
| intRdata | input | 16 | Internal port read data, same cycle |
| extCsN | output | 1 | External cycle in progress, active low |
| extAddr | output | 16 | External address |
| extWdata | output | 16 | External write data |
| extRdN | output | 1 | External read strobe, active low |
| extHwrN | output | 1 | External upper-byte write strobe, active low |
| extLwrN | output | 1 | External lower-byte write strobe, active low |
| extRdata | input | 16 | External read data |
| tendN | output | 1 | Transfer-end strobe, active low |

## Verification
The assertions assume that a presented request keeps all its fields steady until reqReady. They also assume that only one request port exists, so no internal request can arrive while a non-posted external access is still pending. The bench drives every request through one task that holds the fields until acceptance, and it issues requests strictly one after another. Random stimulus mixes internal and external reads and writes, with bufEnable toggled at random. Expected stall counts come from a bench-side count of the buffer cycles still outstanding.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef struct packed {
    logic load;     // capture the presented external request into the buffer
    logic posted;   // the captured entry is a posted write
    logic intGo;    // drive the internal port this cycle
    logic selExt;   // response data comes from the external port
  } pwbCtrlT;
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbCtrlT           ctrl,
  input  logic              reqWrite,
  input  logic              reqLast,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqHiEn,
  input  logic              reqLoEn,
  input  logic [DATA_W-1:0] intRdata,
  input  logic [DATA_W-1:0] extRdata,
  output logic              bufWrite,
  output logic              bufPosted,
  output logic              bufLast,
  output logic              bufHi,
  output logic              bufLo,
  output logic [DATA_W-1:0] rspData,
  output logic              intSel,
  output logic              intWrite,
  output logic [ADDR_W-1:0] intAddr,
  output logic [DATA_W-1:0] intWdata,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata
);
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr   <= '0;
      bufData   <= '0;
      bufWrite  <= 1'b0;
      bufPosted <= 1'b0;
      bufLast   <= 1'b0;
      bufHi     <= 1'b0;
      bufLo     <= 1'b0;
    end else if (ctrl.load) begin
      bufAddr   <= reqAddr;
      bufData   <= reqWdata;
      bufWrite  <= reqWrite;
      bufPosted <= ctrl.posted;
      bufLast   <= reqLast;
      bufHi     <= reqHiEn;
      bufLo     <= reqLoEn;
    end
  end

  assign extAddr  = bufAddr;
  assign extWdata = bufData;
  assign rspData  = ctrl.selExt ? extRdata : intRdata;

  assign intSel   = ctrl.intGo;
  assign intWrite = reqWrite;
  assign intAddr  = reqAddr;
  assign intWdata = reqWdata;

  // buffer contents must not change while a loaded entry is being reloaded twice in a row
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> !ctrl.load) else $error("buffer reloaded back to back"); // R6
endmodule

// File: rtl/pwb_control.sv
module pwb_control
  import pwb_pkg::*;
#(
  parameter int WR_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bufEnable,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqDead,
  input  logic    reqLast,
  input  logic    reqExt,
  input  logic    bufWrite,
  input  logic    bufPosted,
  input  logic    bufLast,
  input  logic    bufHi,
  input  logic    bufLo,
  output pwbCtrlT ctrl,
  output logic    reqReady,
  output logic    tendN,
  output logic    extCsN,
  output logic    extRdN,
  output logic    extHwrN,
  output logic    extLwrN
);
  localparam int CW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WR_CYCLES - 2);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SETUP, SEQ_STROBE} seqT;
  seqT           state;
  logic [CW-1:0] cnt;

  logic busy, lastCyc, intReq, extReq, intOk, postNow, loadNow;

  assign busy    = (state != SEQ_IDLE);
  assign lastCyc = (state == SEQ_STROBE) && (cnt == LAST_CNT);
  assign intReq  = reqValid && (!reqExt || reqDead);
  assign extReq  = reqValid && reqExt && !reqDead;
  assign intOk   = !busy || bufPosted;
  assign postNow = reqWrite && bufEnable;
  assign loadNow = extReq && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE:   if (loadNow) state <= SEQ_SETUP;
        SEQ_SETUP: begin
          state <= SEQ_STROBE;
          cnt   <= '0;
        end
        SEQ_STROBE: begin
          if (lastCyc) state <= SEQ_IDLE;
          else         cnt   <= cnt + 1'b1;
        end
        default:    state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl        = '0;
    ctrl.load   = loadNow;
    ctrl.posted = postNow;
    ctrl.intGo  = intReq && intOk && !reqDead;
    ctrl.selExt = busy && !bufPosted;
  end

  assign reqReady = (intReq && intOk)
                  || (loadNow && postNow)
                  || (extReq && busy && !bufPosted && lastCyc);

  assign tendN   = !((busy && bufLast) || (intReq && reqLast && !busy));
  assign extCsN  = !busy;
  assign extRdN  = !((state == SEQ_STROBE) && !bufWrite);
  assign extHwrN = !((state == SEQ_STROBE) && bufWrite && bufHi);
  assign extLwrN = !((state == SEQ_STROBE) && bufWrite && bufLo);

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extCsN) |-> (extRdN && extHwrN && extLwrN)) else $error("strobe in setup"); // R4
  AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bufPosted) |-> !(extReq && reqReady)) else $error("external accepted while busy"); // R6
  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && reqReady && !bufEnable) |-> (!extCsN && $past(!extCsN))) else $error("early ready"); // R2
  AST_TEND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && reqReady && busy) |-> (tendN || bufLast)) else $error("tend on overlapped internal"); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !extRdN |-> (extHwrN && extLwrN)) else $error("read and write strobes together"); // R4
endmodule

// File: rtl/postwr_bus_ctrl.sv
module postwr_bus_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int WR_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufEnable,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqDead,
  input  logic              reqLast,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqHiEn,
  input  logic              reqLoEn,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspData,
  output logic              intSel,
  output logic              intWrite,
  output logic [ADDR_W-1:0] intAddr,
  output logic [DATA_W-1:0] intWdata,
  input  logic [DATA_W-1:0] intRdata,
  output logic              extCsN,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  output logic              extRdN,
  output logic              extHwrN,
  output logic              extLwrN,
  input  logic [DATA_W-1:0] extRdata,
  output logic              tendN
);
  pwbCtrlT ctrl;
  logic    bufWrite, bufPosted, bufLast, bufHi, bufLo;
  logic    reqExt;

  assign reqExt = reqAddr[ADDR_W-1];

  pwb_control #(.WR_CYCLES(WR_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .bufEnable(bufEnable),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqDead(reqDead),
    .reqLast(reqLast), .reqExt(reqExt),
    .bufWrite(bufWrite), .bufPosted(bufPosted), .bufLast(bufLast),
    .bufHi(bufHi), .bufLo(bufLo),
    .ctrl(ctrl), .reqReady(reqReady), .tendN(tendN),
    .extCsN(extCsN), .extRdN(extRdN), .extHwrN(extHwrN), .extLwrN(extLwrN)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqWrite(reqWrite), .reqLast(reqLast), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqHiEn(reqHiEn), .reqLoEn(reqLoEn),
    .intRdata(intRdata), .extRdata(extRdata),
    .bufWrite(bufWrite), .bufPosted(bufPosted), .bufLast(bufLast),
    .bufHi(bufHi), .bufLo(bufLo),
    .rspData(rspData), .intSel(intSel), .intWrite(intWrite),
    .intAddr(intAddr), .intWdata(intWdata),
    .extAddr(extAddr), .extWdata(extWdata)
  );

  AST_DEAD_NO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDead) |-> !intSel) else $error("dead cycle touched internal port"); // R10
endmodule

// File: tb/sim_postwr_bus_ctrl.sv
module sim_postwr_bus_ctrl;
  localparam int WRC = 3;

  logic clk = 1'b0, rstN = 1'b0, bufEnable = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqDead = 1'b0, reqLast = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic reqHiEn = 1'b0, reqLoEn = 1'b0;
  logic reqReady, intSel, intWrite, extCsN, extRdN, extHwrN, extLwrN, tendN;
  logic [15:0] rspData, intAddr, intWdata, intRdata, extAddr, extWdata, extRdata;

  int checks = 0, errors = 0;
  logic [15:0] extMem [16];
  logic [15:0] intMem [16];
  logic [15:0] refExt [16];
  logic [15:0] refInt [16];

  always #10 clk = ~clk;

  postwr_bus_ctrl #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rstN(rstN), .bufEnable(bufEnable), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqDead(reqDead), .reqLast(reqLast), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqHiEn(reqHiEn), .reqLoEn(reqLoEn), .reqReady(reqReady),
    .rspData(rspData), .intSel(intSel), .intWrite(intWrite), .intAddr(intAddr),
    .intWdata(intWdata), .intRdata(intRdata), .extCsN(extCsN), .extAddr(extAddr),
    .extWdata(extWdata), .extRdN(extRdN), .extHwrN(extHwrN), .extLwrN(extLwrN),
    .extRdata(extRdata), .tendN(tendN)
  );

  // device models
  assign extRdata = extMem[extAddr[3:0]];
  assign intRdata = intMem[intAddr[3:0]];
  always @(posedge clk) begin
    if (!extHwrN) extMem[extAddr[3:0]][15:8] <= extWdata[15:8];
    if (!extLwrN) extMem[extAddr[3:0]][7:0]  <= extWdata[7:0];
    if (intSel && intWrite) intMem[intAddr[3:0]] <= intWdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic hi, input logic lo);
    return {hi ? d[15:8] : old[15:8], lo ? d[7:0] : old[7:0]};
  endfunction

  // presents one request, holds it until accepted
  task automatic issue(input logic wr, input logic dead, input logic last,
                       input logic [15:0] a, input logic [15:0] d,
                       input logic hi, input logic lo,
                       output int waits, output logic [15:0] rd,
                       output logic cs, output logic tend, output logic isel);
    waits = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqDead = dead; reqLast = last;
    reqAddr = a; reqWdata = d; reqHiEn = hi; reqLoEn = lo;
    forever begin
      #2;
      if (reqReady) begin
        rd = rspData; cs = extCsN; tend = tendN; isel = intSel;
        break;
      end
      waits++;
      if (waits > 100) begin
        chk(1'b0, "hang", waits, 0);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 reqValid = 1'b0; reqLast = 1'b0; reqDead = 1'b0;
    if (wr && !dead) begin
      if (a[15]) refExt[a[3:0]] = merge(refExt[a[3:0]], d, hi, lo);
      else       refInt[a[3:0]] = d;
    end
  endtask

  int w;
  logic [15:0] rd;
  logic cs, tnd, isel;
  int busyLeft;

  initial begin
    for (int i = 0; i < 16; i++) begin
      extMem[i] = 16'(i * 16'h0101); refExt[i] = 16'(i * 16'h0101);
      intMem[i] = 16'(i * 16'h1111); refInt[i] = 16'(i * 16'h1111);
    end
    void'($urandom(32'd2024));
    fork
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    #2;
    chk(extCsN && extRdN && extHwrN && extLwrN && tendN, "R1 idle outputs in reset", 
        {extCsN, extRdN, extHwrN, extLwrN, tendN}, 5'h1f);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(extCsN && tendN && !reqReady, "R1 idle after reset", {extCsN, tendN, reqReady}, 3'b110);

    // R2: unbuffered external write stalls for the whole sequence
    bufEnable = 1'b0;
    issue(1, 0, 0, 16'h8001, 16'h1234, 1, 1, w, rd, cs, tnd, isel);
    chk(w == WRC, "R2 stall length", w, WRC);

    // R3/R4: posted write accepted at once, then setup and strobe phases
    bufEnable = 1'b1;
    issue(1, 0, 0, 16'h8002, 16'hBEEF, 1, 0, w, rd, cs, tnd, isel);
    chk(w == 0, "R3 posted accept", w, 0);
    @(negedge clk); #2;
    chk(!extCsN && extHwrN && extLwrN, "R4 setup phase", {extCsN, extHwrN, extLwrN}, 3'b011);
    for (int k = 1; k < WRC; k++) begin
      @(negedge clk); #2;
      chk(!extHwrN && extLwrN && extAddr == 16'h8002 && extWdata == 16'hBEEF,
          "R4 strobe phase hi lane only", {extHwrN, extLwrN, extAddr}, {2'b01, 16'h8002});
    end
    @(negedge clk); #2;
    chk(extCsN, "R4 sequence ends", extCsN, 1);

    // R5/R10/R9: internal accesses and dead cycle overlap a posted write
    issue(1, 0, 0, 16'h8005, 16'h0F0F, 1, 1, w, rd, cs, tnd, isel);
    issue(1, 0, 0, 16'h0003, 16'h5A5A, 1, 1, w, rd, cs, tnd, isel);
    chk(w == 0 && !cs && isel, "R5 internal write overlaps", {w[3:0], cs, isel}, 6'b000001);
    issue(0, 0, 1, 16'h0003, 16'h0, 1, 1, w, rd, cs, tnd, isel);
    chk(w == 0 && !cs && rd == 16'h5A5A, "R5 internal read overlaps", rd, 16'h5A5A);
    chk(tnd, "R9 tend withheld on overlapped internal", tnd, 1);
    issue(0, 1, 1, 16'h0000, 16'h0, 0, 0, w, rd, cs, tnd, isel);
    chk(w == 0 && !isel && tnd, "R10 dead cycle overlaps without intSel", {w[3:0], isel, tnd}, 6'b000001);

    // R6/R7: read right after posted write waits for drain then its own sequence
    issue(1, 0, 0, 16'h8007, 16'hC0DE, 1, 1, w, rd, cs, tnd, isel);
    issue(0, 0, 0, 16'h8007, 16'h0, 1, 1, w, rd, cs, tnd, isel);
    chk(w == 2 * WRC, "R6 read held behind buffer", w, 2 * WRC);
    chk(rd == 16'hC0DE, "R7 read returns buffered data", rd, 16'hC0DE);
    issue(1, 0, 0, 16'h8008, 16'h1111, 1, 1, w, rd, cs, tnd, isel);
    issue(1, 0, 0, 16'h8009, 16'h2222, 1, 1, w, rd, cs, tnd, isel);
    chk(w == WRC, "R6 second posted write waits", w, WRC);

    // R9: final internal and dead cycles with nothing running
    repeat (WRC + 1) @(negedge clk);
    issue(0, 0, 1, 16'h0001, 16'h0, 1, 1, w, rd, cs, tnd, isel);
    chk(!tnd && cs, "R9 tend on idle internal", tnd, 0);
    issue(0, 1, 1, 16'h0000, 16'h0, 0, 0, w, rd, cs, tnd, isel);
    chk(!tnd && !isel, "R9 R10 tend on idle dead cycle", {tnd, isel}, 0);

    // R8: final transfer as external posted write
    issue(1, 0, 1, 16'h800A, 16'h7777, 1, 1, w, rd, cs, tnd, isel);
    chk(tnd, "R8 tend not early", tnd, 1);
    for (int k = 0; k < WRC; k++) begin
      @(negedge clk); #2;
      chk(!tendN, "R8 tend during external cycle", tendN, 0);
    end
    @(negedge clk); #2;
    chk(tendN, "R8 tend released", tendN, 1);

    // burst copy: internal read, external write, ends with dead cycle
    for (int u = 0; u < 4; u++) begin
      issue(0, 0, 0, 16'(u), 16'h0, 1, 1, w, rd, cs, tnd, isel);
      chk(rd == refInt[u], "R5 burst source read", rd, refInt[u]);
      issue(1, 0, 0, 16'h8000 | 16'(u), rd, 1, 1, w, rd, cs, tnd, isel);
    end
    issue(0, 1, 1, 16'h0, 16'h0, 0, 0, w, rd, cs, tnd, isel);
    chk(tnd && !cs, "R9 burst dead cycle tend withheld", tnd, 1);

    // random mix
    repeat (WRC + 2) @(negedge clk);
    busyLeft = 0;
    for (int n = 0; n < 300; n++) begin
      logic ext, wr, hi, lo, en;
      logic [3:0] ix;
      logic [15:0] dat;
      int expW;
      ext = 1'($urandom); wr = 1'($urandom); en = 1'($urandom);
      hi = 1'($urandom); lo = 1'($urandom); ix = 4'($urandom); dat = 16'($urandom);
      bufEnable = en;
      if (!ext) expW = 0;
      else      expW = busyLeft + ((wr && en) ? 0 : WRC);
      issue(wr, 0, 0, {ext, 11'd0, ix}, dat, hi, lo, w, rd, cs, tnd, isel);
      chk(w == expW, ext ? "R6 random external stall" : "R5 random internal", w, expW);
      if (!wr) chk(rd == (ext ? refExt[ix] : refInt[ix]), "R7 random read data",
                   rd, ext ? refExt[ix] : refInt[ix]);
      if (ext) busyLeft = (wr && en) ? WRC : 0;
      else     busyLeft = (busyLeft > 0) ? busyLeft - 1 : 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule